// File: doc/BRIEF.md
# System Control Coprocessor Register Bank

This block is a small bank of control registers that sits beside a processor core and is reached through coprocessor register-transfer operations. The core presents an instruction word together with a direction flag; the register index is taken from the instruction word. A write stores the core's data, and a read returns a register's contents in the same cycle with a done response. The bank never stalls the core.

Two registers have special meaning. Index 0 is an identification register: it always reads back a fixed constant, whatever has been written to it. Index 1 is the mode register. Four of its bits drive live mode-control outputs to the core: program address width, data address width, abort timing and byte order. These bits are loaded from external strap inputs at reset. Every write to index 1 raises a one-cycle re-evaluate pulse so the core notices the new modes. A separate debug path has its own read and write ports, which accept a wider index and handle out-of-range values safely.

Top module: `sysctl_cp`

## Requirements
- R1: The register index of a core transfer is instruction bits 18:16. Bit 19 is ignored, so index 9 addresses register 1.
- R2: A core read of register 0 returns 0x41440110, even after register 0 has been written by the core or by the debug port.
- R3: A debug read returns 0x41440110 for index 0, the stored value for indices 1 to 7, and zero for indices 8 to 15. It reflects the contents before any write in the same cycle.
- R4: A debug write with an index of 8 or above changes no register and produces no re-evaluate pulse.
- R5: Synchronous reset clears registers 2 to 7. It loads register 1 with strap bits 3:0 in bits 7:4 and zero in every other bit, and holds the re-evaluate pulse low.
- R6: The mode outputs always equal register 1: bit 4 drives mode_prog32, bit 5 drives mode_data32, bit 6 drives mode_late_abort and bit 7 drives mode_big_endian. A write becomes visible after the clock edge that performs it.
- R7: Each write to register 1, from the core or from the debug port, sets mode_changed high for exactly the following cycle, even if the value is unchanged. Writes to other registers produce no pulse.
- R8: Bits 3:0 and 31:8 of register 1 are stored and read back, but have no effect on the mode outputs.
- R9: xfer_done is high in every cycle in which xfer_valid is high, for reads and for writes alike.
- R10: When the core and the debug port write the same register in one cycle, the core's data is kept. Writes to different registers in one cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_mode | input | 4 | Reset values for mode bits {big_endian, late_abort, data32, prog32} |
| xfer_valid | input | 1 | Core register-transfer operation present |
| xfer_write | input | 1 | 1 = core writes the register, 0 = core reads it |
| xfer_instr | input | 32 | Instruction word; bits 18:16 select the register |
| xfer_wdata | input | 32 | Core write data |
| xfer_rdata | output | 32 | Core read data (zero when not reading) |
| xfer_done | output | 1 | Operation complete this cycle |
| dbg_wr_en | input | 1 | Debug write strobe |
| dbg_wr_idx | input | 4 | Debug write index |
| dbg_wr_data | input | 32 | Debug write data |
| dbg_rd_idx | input | 4 | Debug read index |
| dbg_rd_data | output | 32 | Debug read data |
| mode_prog32 | output | 1 | Program address space is 32-bit |
| mode_data32 | output | 1 | Data address space is 32-bit |
| mode_late_abort | output | 1 | Late abort timing selected |
| mode_big_endian | output | 1 | Big-endian byte order selected |
| mode_changed | output | 1 | One-cycle pulse after a write to register 1 |

## Verification
The core transfer port and the debug write port can both write in one clock edge, and both can target register 1. The bench provokes this case with same-index and different-index pairs, including pairs that both hit the mode register. A per-cycle reference model applies debug data first and core data on top. The stored word, the mode outputs and a single re-evaluate pulse are then compared against the model after the edge. The bench also reads through the debug port during a write to confirm the pre-edge value is returned.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned WORD_W      = 32;
    localparam int unsigned IDX_LSB     = 16;
    localparam logic [WORD_W-1:0] ID_WORD = 32'h4144_0110;
    localparam int unsigned MODE_REG    = 1;
    localparam int unsigned MODE_LSB    = 4;

    // Mode field of the mode register, bit 0 of the struct at MODE_LSB.
    typedef struct packed {
        logic big_endian;
        logic late_abort;
        logic data32;
        logic prog32;
    } mode_t;

    localparam int unsigned MODE_W = $bits(mode_t);

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_DBG  = 2'd1,
        SRC_CORE = 2'd2
    } wsrc_e;

    function automatic logic [2:0] instr_index(input logic [WORD_W-1:0] instr);
        return instr[IDX_LSB +: 3];
    endfunction

    function automatic mode_t extract_mode(input logic [WORD_W-1:0] word);
        return mode_t'(word[MODE_LSB +: MODE_W]);
    endfunction

endpackage

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned DATA_W   = WORD_W,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [MODE_W-1:0]                strap,
    input  logic                             core_we,
    input  logic [IDX_W-1:0]                 core_idx,
    input  logic [DATA_W-1:0]                core_wd,
    input  logic                             dbg_we,
    input  logic [IDX_W-1:0]                 dbg_idx,
    input  logic [DATA_W-1:0]                dbg_wd,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);

    // Register 0 holds nothing observable: reads always see the ID word.
    assign regs_q[0] = '0;

    for (genvar g = 1; g < NUM_REGS; g++) begin : g_reg
        logic [DATA_W-1:0] r_q;
        logic [DATA_W-1:0] rst_val;
        wsrc_e             src;

        if (g == MODE_REG) begin : g_mode_rst
            always_comb begin
                rst_val = '0;
                rst_val[MODE_LSB +: MODE_W] = strap;
            end
        end else begin : g_zero_rst
            assign rst_val = '0;
        end

        always_comb begin
            if (core_we && core_idx == IDX_W'(g))
                src = SRC_CORE;
            else if (dbg_we && dbg_idx == IDX_W'(g))
                src = SRC_DBG;
            else
                src = SRC_NONE;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                r_q <= rst_val;
            end else begin
                case (src)
                    SRC_CORE: r_q <= core_wd;
                    SRC_DBG:  r_q <= dbg_wd;
                    default:  r_q <= r_q;
                endcase
            end
        end

        assign regs_q[g] = r_q;
    end

endmodule

// File: rtl/sysctl_mode_ctrl.sv
module sysctl_mode_ctrl
    import sysctl_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [DATA_W-1:0] mode_word,
    output mode_t             mode,
    output logic              changed
);

    assign mode = extract_mode(mode_word);

    always_ff @(posedge clk) begin
        if (rst)
            changed <= 1'b0;
        else
            changed <= mode_wr;
    end

endmodule

// File: rtl/sysctl_cp.sv
module sysctl_cp
    import sysctl_pkg::*;
#(
    parameter int unsigned NUM_REGS  = 8,
    parameter int unsigned DATA_W    = WORD_W,
    parameter int unsigned DBG_IDX_W = 4,
    parameter logic [DATA_W-1:0] ID_VALUE = ID_WORD
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [3:0]           strap_mode,
    input  logic                 xfer_valid,
    input  logic                 xfer_write,
    input  logic [31:0]          xfer_instr,
    input  logic [DATA_W-1:0]    xfer_wdata,
    output logic [DATA_W-1:0]    xfer_rdata,
    output logic                 xfer_done,
    input  logic                 dbg_wr_en,
    input  logic [DBG_IDX_W-1:0] dbg_wr_idx,
    input  logic [DATA_W-1:0]    dbg_wr_data,
    input  logic [DBG_IDX_W-1:0] dbg_rd_idx,
    output logic [DATA_W-1:0]    dbg_rd_data,
    output logic                 mode_prog32,
    output logic                 mode_data32,
    output logic                 mode_late_abort,
    output logic                 mode_big_endian,
    output logic                 mode_changed
);

    localparam int unsigned IDX_W = $clog2(NUM_REGS);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
    logic [IDX_W-1:0] core_idx;
    logic [IDX_W-1:0] dbg_widx;
    logic [IDX_W-1:0] dbg_ridx;
    logic             core_we;
    logic             dbg_we;
    logic             dbg_rd_ok;
    logic             mode_wr;
    mode_t            mode;

    assign core_idx  = IDX_W'(instr_index(xfer_instr));
    assign core_we   = xfer_valid && xfer_write;
    assign dbg_widx  = IDX_W'(dbg_wr_idx);
    assign dbg_ridx  = IDX_W'(dbg_rd_idx);
    assign dbg_we    = dbg_wr_en && (32'(dbg_wr_idx) < NUM_REGS);
    assign dbg_rd_ok = 32'(dbg_rd_idx) < NUM_REGS;
    assign mode_wr   = (core_we && core_idx == IDX_W'(MODE_REG)) ||
                       (dbg_we  && dbg_widx == IDX_W'(MODE_REG));

    sysctl_regfile #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W)
    ) u_regfile (
        .clk      (clk),
        .rst      (rst),
        .strap    (strap_mode),
        .core_we  (core_we),
        .core_idx (core_idx),
        .core_wd  (xfer_wdata),
        .dbg_we   (dbg_we),
        .dbg_idx  (dbg_widx),
        .dbg_wd   (dbg_wr_data),
        .regs_q   (regs_q)
    );

    sysctl_mode_ctrl #(
        .DATA_W (DATA_W)
    ) u_mode (
        .clk       (clk),
        .rst       (rst),
        .mode_wr   (mode_wr),
        .mode_word (regs_q[MODE_REG]),
        .mode      (mode),
        .changed   (mode_changed)
    );

    always_comb begin
        xfer_rdata = '0;
        if (xfer_valid && !xfer_write)
            xfer_rdata = (core_idx == '0) ? ID_VALUE : regs_q[core_idx];
    end

    always_comb begin
        dbg_rd_data = '0;
        if (dbg_rd_ok)
            dbg_rd_data = (dbg_ridx == '0) ? ID_VALUE : regs_q[dbg_ridx];
    end

    assign xfer_done       = xfer_valid;
    assign mode_prog32     = mode.prog32;
    assign mode_data32     = mode.data32;
    assign mode_late_abort = mode.late_abort;
    assign mode_big_endian = mode.big_endian;

endmodule

// File: rtl/sysctl_cp_chk.sv
module sysctl_cp_chk (
    input logic        clk,
    input logic        rst,
    input logic        xfer_valid,
    input logic        xfer_write,
    input logic [31:0] xfer_instr,
    input logic [31:0] xfer_rdata,
    input logic        dbg_wr_en,
    input logic [3:0]  dbg_wr_idx,
    input logic [3:0]  dbg_rd_idx,
    input logic [31:0] dbg_rd_data,
    input logic        mode_prog32,
    input logic        mode_data32,
    input logic        mode_late_abort,
    input logic        mode_big_endian,
    input logic        mode_changed
);

    logic       wr_mode;
    logic [3:0] mode_v;

    assign wr_mode = (xfer_valid && xfer_write && xfer_instr[18:16] == 3'd1) ||
                     (dbg_wr_en && dbg_wr_idx == 4'd1);
    assign mode_v  = {mode_big_endian, mode_late_abort, mode_data32, mode_prog32};

    // R2: core read of index 0 gives the identification word
    a_r2_id_read: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && !xfer_write && xfer_instr[18:16] == 3'd0)
            |-> xfer_rdata == 32'h4144_0110);

    // R3: out-of-range debug reads return zero
    a_r3_dbg_high_zero: assert property (@(posedge clk) disable iff (rst)
        (dbg_rd_idx >= 4'd8) |-> dbg_rd_data == 32'd0);

    // R6: mode outputs match register 1 as seen on the debug read port
    a_r6_mode_tracks: assert property (@(posedge clk) disable iff (rst)
        (dbg_rd_idx == 4'd1) |-> mode_v == dbg_rd_data[7:4]);

    // R6: mode outputs hold when register 1 is not written
    a_r6_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_mode |=> $stable(mode_v));

    // R7: a write to register 1 is followed by the pulse
    a_r7_pulse_after_write: assert property (@(posedge clk) disable iff (rst)
        wr_mode |=> mode_changed);

    // R7: the pulse appears only after a write to register 1
    a_r7_pulse_cause: assert property (@(posedge clk) disable iff (rst)
        (mode_changed && !$past(rst)) |-> $past(wr_mode));

endmodule

bind sysctl_cp sysctl_cp_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .xfer_valid      (xfer_valid),
    .xfer_write      (xfer_write),
    .xfer_instr      (xfer_instr),
    .xfer_rdata      (xfer_rdata),
    .dbg_wr_en       (dbg_wr_en),
    .dbg_wr_idx      (dbg_wr_idx),
    .dbg_rd_idx      (dbg_rd_idx),
    .dbg_rd_data     (dbg_rd_data),
    .mode_prog32     (mode_prog32),
    .mode_data32     (mode_data32),
    .mode_late_abort (mode_late_abort),
    .mode_big_endian (mode_big_endian),
    .mode_changed    (mode_changed)
);

// File: tb/test_sysctl_cp.sv
module test_sysctl_cp;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] ID = 32'h4144_0110;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  strap_mode;
    logic        xfer_valid;
    logic        xfer_write;
    logic [31:0] xfer_instr;
    logic [31:0] xfer_wdata;
    logic [31:0] xfer_rdata;
    logic        xfer_done;
    logic        dbg_wr_en;
    logic [3:0]  dbg_wr_idx;
    logic [31:0] dbg_wr_data;
    logic [3:0]  dbg_rd_idx;
    logic [31:0] dbg_rd_data;
    logic        mode_prog32, mode_data32, mode_late_abort, mode_big_endian;
    logic        mode_changed;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] m_reg [8];
    logic        m_pulse;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_cp i_sysctl_cp (
        .clk, .rst, .strap_mode,
        .xfer_valid, .xfer_write, .xfer_instr, .xfer_wdata, .xfer_rdata, .xfer_done,
        .dbg_wr_en, .dbg_wr_idx, .dbg_wr_data, .dbg_rd_idx, .dbg_rd_data,
        .mode_prog32, .mode_data32, .mode_late_abort, .mode_big_endian, .mode_changed
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_dbg_read(input logic [3:0] idx);
        if (idx >= 8) return 32'd0;
        if (idx == 0) return ID;
        return m_reg[idx];
    endfunction

    // Drive one cycle: comb outputs checked before the edge, registered after it.
    task automatic step(input string req,
                        input bit v, input bit w, input logic [3:0] ridx, input logic [31:0] wd,
                        input bit de, input logic [3:0] didx, input logic [31:0] dd,
                        input logic [3:0] rdidx);
        int ci;
        logic [31:0] exp_r;
        xfer_valid  = v;
        xfer_write  = w;
        xfer_instr  = 32'hE000_0F10 | (32'(ridx) << 16);
        xfer_wdata  = wd;
        dbg_wr_en   = de;
        dbg_wr_idx  = didx;
        dbg_wr_data = dd;
        dbg_rd_idx  = rdidx;
        ci = int'(ridx[2:0]);
        #1;
        exp_r = (v && !w) ? ((ci == 0) ? ID : m_reg[ci]) : 32'd0;
        check({req, " R9 done"}, 32'(xfer_done), 32'(v));
        check({req, " core read"}, xfer_rdata, exp_r);
        check({req, " R3 debug read"}, dbg_rd_data, exp_dbg_read(rdidx));
        @(posedge clk);
        m_pulse = (v && w && ci == 1) || (de && didx == 4'd1);
        if (de && didx < 8) m_reg[didx] = dd;
        if (v && w) m_reg[ci] = wd;
        @(negedge clk);
        check({req, " R6 mode"},
              32'({mode_big_endian, mode_late_abort, mode_data32, mode_prog32}),
              32'(m_reg[1][7:4]));
        check({req, " R7 pulse"}, 32'(mode_changed), 32'(m_pulse));
    endtask

    task automatic core_wr(input string req, input logic [3:0] idx, input logic [31:0] d);
        step(req, 1, 1, idx, d, 0, 0, 0, 4'd1);
    endtask
    task automatic core_rd(input string req, input logic [3:0] idx);
        step(req, 1, 0, idx, 0, 0, 0, 0, 4'd1);
    endtask
    task automatic dbg_wr(input string req, input logic [3:0] idx, input logic [31:0] d);
        step(req, 0, 0, 0, 0, 1, idx, d, 4'd1);
    endtask
    task automatic dbg_rd(input string req, input logic [3:0] idx);
        step(req, 0, 0, 0, 0, 0, 0, 0, idx);
    endtask

    initial begin
        rst = 1'b1;
        strap_mode = 4'b1010;
        xfer_valid = 0; xfer_write = 0; xfer_instr = 0; xfer_wdata = 0;
        dbg_wr_en = 0; dbg_wr_idx = 0; dbg_wr_data = 0; dbg_rd_idx = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) m_reg[i] = 32'd0;
        m_reg[1] = 32'h0000_00A0;
        m_pulse = 0;
        // R5: reset state
        check("R5 reg1 after reset", dbg_rd_data, 32'h0000_00A0);
        check("R5 pulse low", 32'(mode_changed), 32'd0);
        for (int i = 2; i < 8; i++) dbg_rd("R5 cleared reg", 4'(i));

        // Core writes and reads of ordinary registers
        for (int i = 2; i < 8; i++) core_wr("R7 no pulse other reg", 4'(i), 32'h1111_0000 * i + 32'h5A);
        for (int i = 2; i < 8; i++) core_rd("core readback", 4'(i));

        // R2: register 0 identification, after core and debug writes
        core_wr("R2 write reg0", 4'd0, 32'hDEAD_BEEF);
        core_rd("R2 id read", 4'd0);
        dbg_wr("R2 dbg write reg0", 4'd0, 32'h1234_5678);
        core_rd("R2 id read after dbg", 4'd0);
        dbg_rd("R3 id dbg read", 4'd0);

        // R6/R8: mode register, other bits stored without effect
        core_wr("R6 mode write", 4'd1, 32'hFFFF_FF5F);
        core_rd("R8 readback", 4'd1);
        core_wr("R8 other bits only", 4'd1, 32'hABCD_EA5F);
        core_wr("R7 same value again", 4'd1, 32'hABCD_EA5F);
        step("R7 idle", 0, 0, 0, 0, 0, 0, 0, 4'd1);

        // R1: bit 19 ignored
        core_wr("R1 index 9 hits reg1", 4'd9, 32'h0000_0030);
        core_rd("R1 index 9 read", 4'd9);
        core_wr("R1 index 11 hits reg3", 4'd11, 32'hCAFE_0003);
        dbg_rd("R1 reg3 via debug", 4'd3);

        // R4/R3: debug out-of-range
        for (int i = 8; i < 16; i++) dbg_wr("R4 ignored high index", 4'(i), 32'hFFFF_FFFF);
        for (int i = 0; i < 16; i++) dbg_rd("R3 R4 debug sweep", 4'(i));
        dbg_wr("R7 dbg write reg1", 4'd1, 32'h0000_00C0);

        // R10: simultaneous writes
        step("R10 same reg1", 1, 1, 4'd1, 32'h0000_0010, 1, 4'd1, 32'h0000_00E0, 4'd1);
        step("R10 same reg4", 1, 1, 4'd4, 32'h4444_4444, 1, 4'd4, 32'h9999_9999, 4'd4);
        dbg_rd("R10 reg4 core wins", 4'd4);
        step("R10 diff regs", 1, 1, 4'd5, 32'h5555_0005, 1, 4'd1, 32'h0000_0090, 4'd5);
        dbg_rd("R10 reg5", 4'd5);
        step("R10 core reg1 dbg reg6", 1, 1, 4'd1, 32'h0000_0070, 1, 4'd6, 32'h6666_0006, 4'd6);
        dbg_rd("R10 reg6", 4'd6);
        step("R3 read during write", 0, 0, 0, 0, 1, 4'd7, 32'h7777_7777, 4'd7);
        dbg_rd("R3 reg7 new", 4'd7);
        step("R9 idle", 0, 0, 0, 0, 0, 0, 0, 4'd1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule